// File: doc/BRIEF.md
# Compare-Cleared 16-bit Timer/Counter

The block is a 16-bit up-counter held as two byte registers, with a six-bit control register, a selectable 1/2/4/8 prescaler and a sticky overflow flag. It counts either pulses of an internal tick enable (timer mode) or rising edges of an external clock pin that are first synchronised into the system clock domain (synchronised counter mode). Software reaches the two count bytes and the control register through a plain byte-wide register bus. The bus carries no stream, so it has no valid/ready handshake: a write takes effect at the clock edge where `wr_en` is high, and a read is a combinational mux on `rd_addr`.

A neighbouring compare unit may pulse `trig` when its match occurs. The pulse clears the count to zero, so the compare value acts as the timer's period. This clear never raises the overflow flag. A software write to a count byte in the same cycle beats the pulse. Writing either count byte also empties the prescaler, so the next counted period starts clean.

Top module: `tmr16_trig`

## Requirements
- R1: The register map is: address 0 holds the count bits 7:0, address 1 holds the count bits 15:8, and address 2 is control. Control reads back as {2'b00, ps[1:0], osc_en, sync_ctl, src_ext, run}, at bits 7:6, 5:4, 3, 2, 1 and 0. Bits 7:6 always read 0, and address 3 reads 8'h00. `osc_en` and `sync_ctl` are storage only.
- R2: While `rst_n` is low, control clears to 8'h00 and the overflow flag clears. The two count bytes keep their value.
- R3: In timer mode (`src_ext`=0, `run`=1, ps=00), each cycle with `tick_int` high advances the count by one at that clock edge.
- R4: Prescale select ps = 00, 01, 10 and 11 divides the selected source by 1, 2, 4 and 8. After a prescaler clear, the count advances on the Nth qualifying source event.
- R5: A write to either count byte clears the prescaler.
- R6: With `run`=0, the count holds and the prescaler does not advance on source events. Register writes still take effect.
- R7: An increment from 16'hFFFF to 16'h0000 sets `ovf_flag`. The flag stays set until a cycle with `ovf_clr` high. A set in the same cycle as `ovf_clr` wins.
- R8: A cycle with `trig` high and no count-byte write loads 16'h0000 at that edge, whatever `run` is. It never sets `ovf_flag`, even when an increment from 16'hFFFF was due in the same cycle.
- R9: A count-byte write in the same cycle as `trig` wins. The written byte takes the bus data, the other byte keeps its value, and the trigger is ignored.
- R10: With `src_ext`=1, `ext_clk` passes through a two-flop synchroniser. A rising edge sampled at clock edge k advances the count at edge k+2. `tick_int` is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset (control, flag, prescaler, synchroniser) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| tick_int | input | 1 | Internal tick enable, one count event per high cycle |
| ext_clk | input | 1 | External clock, asynchronous |
| trig | input | 1 | Compare-unit clear pulse |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two pairs of functions can meet in one cycle, and the bench sets each pair against the other on purpose. The first pair is a trigger pulse and a due increment from 16'hFFFF. The bench drives both in the same cycle and expects a zero count with the flag still clear. The second pair is a trigger pulse and a count-byte write. Here the bench expects the written byte together with the untouched other byte. The prescaler sweep covers all four ratios against arithmetic expectations. A set and a clear of the overflow flag in the same cycle are also driven together.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W   = 8;
  localparam int CTRL_W   = 6;
  localparam logic [1:0] ADR_CTRL = 2'd2;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-1:0], din};
  end

  assign rise = sr[STAGES-1] & ~sr[STAGES];

  // R10: a detected edge lasts exactly one cycle
  a_r10_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr_prediv.sv
module tmr_prediv #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  input  logic [PS_W-1:0] sel,
  output logic            fire
);
  localparam int CW = (1 << PS_W) - 1;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = CW'((1 << sel) - 1);
  assign fire = adv && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (fire) cnt <= '0;
    else if (adv)  cnt <= cnt + 1'b1;
  end

  // R5: a clear empties the prescaler
  a_r5_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  // R6: without a source event the prescaler holds
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cnt));
endmodule

// File: rtl/tmr16_trig.sv
module tmr16_trig #(
  parameter int CNT_W       = 16,
  parameter int PS_W        = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              tick_int,
  input  logic              ext_clk,
  input  logic              trig,
  input  logic              ovf_clr,
  output logic              ovf_flag
);
  import tmr_pkg::*;
  localparam int NBYTES = CNT_W / BYTE_W;

  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [PS_W-1:0]  ps_sel;
  logic             osc_en, sync_ctl, src_ext, run;
  logic             cnt_wr, ext_rise, src_evt, pre_fire, ovf_set;
  logic [7:0]       byte_rd [NBYTES];

  assign cnt_wr  = wr_en && (wr_addr < ADDR_W'(NBYTES));
  assign src_evt = run && (src_ext ? ext_rise : tick_int);

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_clk), .rise(ext_rise));

  tmr_prediv #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(cnt_wr), .adv(src_evt),
    .sel(ps_sel), .fire(pre_fire));

  // Priority: byte write, then compare clear, then increment
  always_comb begin
    cnt_nx  = cnt;
    ovf_set = 1'b0;
    if (cnt_wr) begin
      for (int b = 0; b < NBYTES; b++)
        if (wr_addr == ADDR_W'(b)) cnt_nx[b*BYTE_W +: BYTE_W] = wr_data;
    end else if (trig) begin
      cnt_nx = '0;
    end else if (pre_fire) begin
      ovf_set = &cnt;
      cnt_nx  = cnt + 1'b1;
    end
  end

  // Count bytes are deliberately outside every reset
  always_ff @(posedge clk) cnt <= cnt_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ps_sel, osc_en, sync_ctl, src_ext, run} <= '0;
    end else if (wr_en && wr_addr == ADR_CTRL) begin
      {ps_sel, osc_en, sync_ctl, src_ext, run} <= wr_data[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (ovf_set) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_rd
    assign byte_rd[g] = cnt[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int b = 0; b < NBYTES; b++)
      if (rd_addr == ADDR_W'(b)) rd_data = byte_rd[b];
    if (rd_addr == ADR_CTRL)
      rd_data = {2'b00, ps_sel, osc_en, sync_ctl, src_ext, run};
  end

  // R8: an unopposed trigger zeroes the count
  a_r8_trig_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !cnt_wr) |=> cnt == '0);
  // R8: a trigger never raises the flag
  a_r8_no_ovf_on_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !ovf_flag) |=> !ovf_flag);
  // R9: the write beats the trigger
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && wr_en && wr_addr == '0) |=> cnt[7:0] == $past(wr_data));
  // R6: stopped timer without writes or trigger holds its count
  a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr && !trig) |=> $stable(cnt));
  // R7: flag rises only with a rollover to zero
  a_r7_rise_rollover: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> cnt == '0);
endmodule

// File: tb/tmr16_trig_tb.sv
module tmr16_trig_tb_top;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, tick_int = 0, ext_clk = 0, trig = 0, ovf_clr = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic       ovf_flag;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr16_trig dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tick_int(tick_int),
    .ext_clk(ext_clk), .trig(trig), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle from a falling edge to the next
  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d,
                      input logic tk, input logic tg, input logic oc);
    wr_en = we; wr_addr = a; wr_data = d; tick_int = tk; trig = tg; ovf_clr = oc;
    @(negedge clk);
    wr_en = 0; tick_int = 0; trig = 0; ovf_clr = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1, a, d, 0, 0, 0);
  endtask
  task automatic tick();
    step(0, 0, 0, 1, 0, 0);
  endtask
  task automatic set_cnt(input int v);
    wr(0, v[7:0]); wr(1, v[15:8]);
  endtask
  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a; #1 v = rd_data;
  endtask
  task automatic rd_cnt(output int v);
    int h, l;
    rd(1, h); rd(0, l); v = (h << 8) | l;
  endtask

  initial begin
    int v;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2, v);  chk("R2 reset control", v, 0);
    chk("R2 reset flag", ovf_flag, 0);

    // R1: map and readback
    wr(2, 8'hFE); rd(2, v); chk("R1 ctrl upper bits read 0", v, 8'h3E);
    rd(3, v); chk("R1 unused address", v, 0);
    set_cnt(16'hA55A); rd(0, v); chk("R1 low byte", v, 8'h5A);
    rd(1, v); chk("R1 high byte", v, 8'hA5);

    // R3/R4: sweep all prescale ratios
    for (int ps = 0; ps < 4; ps++) begin
      wr(2, 8'((ps << 4) | 1));
      set_cnt(0);
      for (int k = 1; k <= 17; k++) begin
        tick(); rd_cnt(v);
        chk(ps == 0 ? "R3 timer tick" : "R4 prescale", v, k >> ps);
      end
    end

    // R5: byte write clears a half-filled prescaler
    wr(2, 8'h11); set_cnt(0); tick(); wr(0, 0); tick(); rd_cnt(v);
    chk("R5 prescaler cleared", v, 0);
    tick(); rd_cnt(v); chk("R5 count after clear", v, 1);

    // R6: stopped timer holds count and prescaler; writes still land
    set_cnt(0); tick(); wr(2, 8'h10);
    repeat (3) tick(); rd_cnt(v); chk("R6 hold while off", v, 0);
    wr(2, 8'h11); tick(); rd_cnt(v); chk("R6 prescaler frozen", v, 1);
    wr(2, 8'h10); set_cnt(16'h0777); rd_cnt(v); chk("R6 write while off", v, 16'h0777);

    // R7: rollover and sticky flag
    wr(2, 8'h01); set_cnt(16'hFFFE); tick(); rd_cnt(v);
    chk("R7 at FFFF", v, 16'hFFFF); chk("R7 no flag yet", ovf_flag, 0);
    tick(); rd_cnt(v); chk("R7 wrap", v, 0); chk("R7 flag set", ovf_flag, 1);
    tick(); chk("R7 flag sticky", ovf_flag, 1);
    step(0, 0, 0, 0, 0, 1); chk("R7 flag cleared", ovf_flag, 0);
    set_cnt(16'hFFFF); step(0, 0, 0, 1, 0, 1); chk("R7 set beats clear", ovf_flag, 1);
    step(0, 0, 0, 0, 0, 1);

    // R8: trigger against a due rollover, and with the timer off
    set_cnt(16'hFFFF); step(0, 0, 0, 1, 1, 0); rd_cnt(v);
    chk("R8 trig clears", v, 0); chk("R8 no flag from trig", ovf_flag, 0);
    wr(2, 8'h00); set_cnt(16'h4321); step(0, 0, 0, 0, 1, 0); rd_cnt(v);
    chk("R8 trig when stopped", v, 0);

    // R9: write beats trigger
    set_cnt(16'h1234); step(1, 0, 8'h55, 0, 1, 0); rd_cnt(v);
    chk("R9 low write wins", v, 16'h1255);
    step(1, 1, 8'h66, 0, 1, 0); rd_cnt(v); chk("R9 high write wins", v, 16'h6655);

    // R10: synchronised external edges, two-cycle latency
    wr(2, 8'h03); set_cnt(0);
    for (int p = 1; p <= 3; p++) begin
      ext_clk = 1; @(negedge clk); @(negedge clk); rd_cnt(v);
      chk("R10 not yet counted", v, p - 1);
      @(negedge clk); rd_cnt(v); chk("R10 edge counted", v, p);
      ext_clk = 0; repeat (3) @(negedge clk);
    end
    tick(); tick(); rd_cnt(v); chk("R10 tick ignored", v, 3);

    // R2: reset clears control and flag, keeps count
    wr(2, 8'h01); set_cnt(16'hFFFF); tick();
    set_cnt(16'hABCD); wr(2, 8'h3F);
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
    rd(2, v); chk("R2 ctrl cleared", v, 0);
    chk("R2 flag cleared", ovf_flag, 0);
    rd_cnt(v); chk("R2 count kept", v, 16'hABCD);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule